// File: doc/BRIEF.md
# Flash In-System Programming Command Engine

This block puts a small register file in front of an on-chip word-addressed flash model and turns single register writes into multi-cycle flash operations. Software loads a command code, a byte address and one or two data words, then writes 1 to the start bit. The engine holds the start bit at 1 for the whole operation and drops it when the operation has finished, so software polls that bit to learn completion. Results that return a value (word read, identifiers, checksum) land in the first data register.

The array is split into four regions selected by address bits 21:20. Three regions are protected by update-enable bits that software must set before programming or erasing them. Programming only clears bits and erase sets a whole page back to all ones, like real flash. Any refused operation (protected region, bad alignment, address outside the region, unknown command) sets a sticky fail flag and leaves the array alone. The flag is cleared by writing 1 to it. The checksum needs two commands: one computes the sum over a range and keeps it inside the engine, and a second copies it out.

Register interface: `reg_wr` is a one-cycle write strobe. `reg_rdata` shows the register selected by `reg_addr` in the same cycle. The register offsets are 0 control, 1 command, 2 address, 3 data0, 4 data1 and 5 start. This is a control path with no streaming data, so it has no valid/ready handshake. A write is always accepted, or is ignored as stated below.

Top module: `flash_isp_ctrl`

## Requirements
- R1: After reset every register reads 0 and the start bit is 0.
- R2: Writing 1 to bit 0 of register 5 sets the start bit. The bit reads 1 until the operation completes and 0 afterwards. It never rises without such a write, and the array is written only while it is 1.
- R3: While the start bit is 1, writes to the command, address, data0 and data1 registers and to the enable bits of register 0 are ignored.
- R4: Command 0x00 copies the addressed word into data0.
- R5: Command 0x21 programs one word. The new value is the old value AND data0.
- R6: Command 0x61 programs data0 into the word at an 8-byte-aligned address and data1 into the next word, each by AND. An address that is not 8-byte aligned fails.
- R7: Command 0x22 needs an address aligned to a 2048-byte page and sets every word of that page to 0xFFFFFFFF.
- R8: Control bit 0 enables updates to region 0 (application), bit 1 to region 1 (loader) and bit 2 to region 3 (configuration). Region 2 is always writable. A program or erase to a disabled region fails and leaves the array unchanged.
- R9: Control bit 3 is a fail flag. Any failed operation sets it. It stays set until 1 is written to it, and writing 0 leaves it set. Unknown command codes fail.
- R10: Command 0x0B returns 0xDA. Command 0x0C returns the DEVICE_ID parameter. Command 0x04 returns word (address/4) of the 96-bit UID parameter, with index 0 being bits 31:0. Index 3 or more fails.
- R11: Command 0x2D sums, modulo 2^32, the words starting at the address over data0 bytes. Size 0 gives 0, and a size that is not a multiple of 4 fails. Command 0x0D then returns the last good sum in data0.
- R12: Address bits 21:20 pick the region and bits 23:22 must be 0. By default the application and loader regions are 4096 bytes each and the other two regions are 2048 bytes each. An unaligned word address, or an access reaching past the region end, fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| busy | output | 1 | Copy of the start bit |

## Verification
Directed cases drive each command at legal addresses, at the first address past a region end, and at misaligned addresses. This separates correct region bounds and alignment checks from off-by-one limits. Program patterns are applied on top of earlier programs, which shows AND behaviour rather than overwrite. Erase after program shows the page returning to all ones. Write attempts during a long erase show the register freeze. A seeded random mix of reads, single and double programs and checksums over random ranges in three regions is compared with a bench model of the array, which catches address-translation and accumulation errors.

// File: rtl/flash_isp_pkg.sv
package flash_isp_pkg;

  localparam logic [7:0] CMD_READ    = 8'h00;
  localparam logic [7:0] CMD_PROG32  = 8'h21;
  localparam logic [7:0] CMD_PROG64  = 8'h61;
  localparam logic [7:0] CMD_ERASE   = 8'h22;
  localparam logic [7:0] CMD_CID     = 8'h0B;
  localparam logic [7:0] CMD_UID     = 8'h04;
  localparam logic [7:0] CMD_DID     = 8'h0C;
  localparam logic [7:0] CMD_SUM_RUN = 8'h2D;
  localparam logic [7:0] CMD_SUM_GET = 8'h0D;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_CMD   = 3'd1;
  localparam logic [2:0] RA_ADDR  = 3'd2;
  localparam logic [2:0] RA_DATA0 = 3'd3;
  localparam logic [2:0] RA_DATA1 = 3'd4;
  localparam logic [2:0] RA_GO    = 3'd5;

  localparam int EN_APP   = 0;
  localparam int EN_LDR   = 1;
  localparam int EN_CFG   = 2;
  localparam int FAIL_BIT = 3;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_READ,
    OP_AND,
    OP_FILL,
    OP_SUM
  } isp_op_e;

  typedef struct packed {
    logic    ok;
    isp_op_e op;
    logic    ret;
  } isp_plan_t;

endpackage

// File: rtl/flash_isp_array.sv
module flash_isp_array #(
  parameter int WORDS = 3072,
  parameter int IW    = 12
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [IW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/flash_isp_decode.sv
module flash_isp_decode
  import flash_isp_pkg::*;
#(
  parameter int          PAGE_BYTES = 2048,
  parameter int          APP_W      = 1024,
  parameter int          LDR_W      = 1024,
  parameter int          SPR_W      = 512,
  parameter int          CFG_W      = 512,
  parameter int          IW         = 12,
  parameter int          CW         = 12,
  parameter logic [31:0] DEVICE_ID  = 32'h0,
  parameter logic [95:0] UID        = 96'h0
) (
  input  logic [7:0]    cmd_i,
  input  logic [23:0]   addr_i,
  input  logic [31:0]   size_i,
  input  logic [2:0]    upd_en_i,
  input  logic [31:0]   sum_i,
  output isp_plan_t     plan_o,
  output logic [IW-1:0] start_o,
  output logic [CW-1:0] count_o,
  output logic [31:0]   konst_o
);
  localparam int PW     = PAGE_BYTES / 4;
  localparam int PB_LOG = $clog2(PAGE_BYTES);
  localparam int LDR_B  = APP_W;
  localparam int SPR_B  = APP_W + LDR_W;
  localparam int CFG_B  = SPR_B + SPR_W;

  logic [17:0] woff;
  logic [32:0] base, rwords, sum_end;
  logic        wr_ok, hi_ok, a4, a8, apage, in_rng;

  always_comb begin
    woff = addr_i[19:2];
    case (addr_i[21:20])
      2'd0:    begin base = 33'(0);     rwords = 33'(APP_W); wr_ok = upd_en_i[EN_APP]; end
      2'd1:    begin base = 33'(LDR_B); rwords = 33'(LDR_W); wr_ok = upd_en_i[EN_LDR]; end
      2'd2:    begin base = 33'(SPR_B); rwords = 33'(SPR_W); wr_ok = 1'b1;             end
      default: begin base = 33'(CFG_B); rwords = 33'(CFG_W); wr_ok = upd_en_i[EN_CFG]; end
    endcase
    hi_ok   = (addr_i[23:22] == 2'b00);
    a4      = (addr_i[1:0] == 2'b00);
    a8      = (addr_i[2:0] == 3'b000);
    apage   = (addr_i[PB_LOG-1:0] == '0);
    in_rng  = ({15'd0, woff} < rwords);
    sum_end = {15'd0, woff} + {3'd0, size_i[31:2]};

    plan_o  = '0;
    count_o = CW'(1);
    konst_o = '0;
    start_o = IW'(base + {15'd0, woff});

    case (cmd_i)
      CMD_READ: begin
        plan_o.ok  = hi_ok && a4 && in_rng;
        plan_o.op  = OP_READ;
        plan_o.ret = 1'b1;
      end
      CMD_PROG32: begin
        plan_o.ok = hi_ok && a4 && in_rng && wr_ok;
        plan_o.op = OP_AND;
      end
      CMD_PROG64: begin
        plan_o.ok = hi_ok && a8 && in_rng && wr_ok;
        plan_o.op = OP_AND;
        count_o   = CW'(2);
      end
      CMD_ERASE: begin
        plan_o.ok = hi_ok && apage && in_rng && wr_ok;
        plan_o.op = OP_FILL;
        count_o   = CW'(PW);
      end
      CMD_CID: begin
        plan_o.ok  = 1'b1;
        plan_o.ret = 1'b1;
        konst_o    = 32'h0000_00DA;
      end
      CMD_DID: begin
        plan_o.ok  = 1'b1;
        plan_o.ret = 1'b1;
        konst_o    = DEVICE_ID;
      end
      CMD_UID: begin
        plan_o.ok  = (addr_i[23:4] == '0) && a4 && (addr_i[3:2] != 2'd3);
        plan_o.ret = 1'b1;
        case (addr_i[3:2])
          2'd0:    konst_o = UID[31:0];
          2'd1:    konst_o = UID[63:32];
          default: konst_o = UID[95:64];
        endcase
      end
      CMD_SUM_RUN: begin
        plan_o.ok = hi_ok && a4 && (size_i[1:0] == 2'b00) && (sum_end <= rwords);
        plan_o.op = OP_SUM;
        count_o   = CW'(size_i[31:2]);
      end
      CMD_SUM_GET: begin
        plan_o.ok  = 1'b1;
        plan_o.ret = 1'b1;
        konst_o    = sum_i;
      end
      default: plan_o.ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/flash_isp_engine.sv
module flash_isp_engine
  import flash_isp_pkg::*;
#(
  parameter int IW = 12,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  input  isp_plan_t     plan_i,
  input  logic [IW-1:0] start_i,
  input  logic [CW-1:0] count_i,
  input  logic [31:0]   konst_i,
  input  logic [31:0]   d0_i,
  input  logic [31:0]   d1_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          mem_we_o,
  output logic [IW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  output logic          done_o,
  output logic          fail_set_o,
  output logic          load_o,
  output logic [31:0]   load_val_o,
  output logic [31:0]   sum_o
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_e;

  st_e           st;
  isp_plan_t     pl;
  logic [IW-1:0] idx;
  logic [CW-1:0] left;
  logic [31:0]   res, acc, sum_q;
  logic          second;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pl     <= '0;
      idx    <= '0;
      left   <= '0;
      res    <= '0;
      acc    <= '0;
      sum_q  <= '0;
      second <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (trig_i) begin
            pl     <= plan_i;
            idx    <= start_i;
            left   <= count_i;
            res    <= konst_i;
            acc    <= '0;
            second <= 1'b0;
            if (!plan_i.ok || plan_i.op == OP_NONE || count_i == '0) st <= S_FIN;
            else st <= S_RUN;
          end
        end
        S_RUN: begin
          idx    <= idx + 1'b1;
          left   <= left - 1'b1;
          second <= 1'b1;
          if (pl.op == OP_READ) res <= mem_rdata_i;
          if (pl.op == OP_SUM)  acc <= acc + mem_rdata_i;
          if (left == CW'(1))   st  <= S_FIN;
        end
        default: begin
          if (pl.ok && pl.op == OP_SUM) sum_q <= acc;
          st <= S_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    mem_addr_o  = idx;
    mem_we_o    = (st == S_RUN) && (pl.op == OP_AND || pl.op == OP_FILL);
    mem_wdata_o = (pl.op == OP_FILL) ? 32'hFFFF_FFFF
                                     : (mem_rdata_i & (second ? d1_i : d0_i));
    done_o      = (st == S_FIN);
    fail_set_o  = done_o && !pl.ok;
    load_o      = done_o && pl.ok && pl.ret;
    load_val_o  = res;
    sum_o       = sum_q;
  end
endmodule

// File: rtl/flash_isp_regs.sv
module flash_isp_regs
  import flash_isp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_i,
  input  logic [2:0]  waddr_i,
  input  logic [31:0] wdata_i,
  input  logic        done_i,
  input  logic        fail_set_i,
  input  logic        load_i,
  input  logic [31:0] load_val_i,
  output logic [7:0]  cmd_o,
  output logic [23:0] addr_o,
  output logic [31:0] data0_o,
  output logic [31:0] data1_o,
  output logic [2:0]  upd_en_o,
  output logic        fail_o,
  output logic        trig_o,
  output logic [31:0] rdata_o
);
  logic open_wr;
  assign open_wr = wr_i && !trig_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_o    <= '0;
      addr_o   <= '0;
      data0_o  <= '0;
      data1_o  <= '0;
      upd_en_o <= '0;
      fail_o   <= 1'b0;
      trig_o   <= 1'b0;
    end else begin
      if (open_wr) begin
        case (waddr_i)
          RA_CTRL:  upd_en_o <= wdata_i[2:0];
          RA_CMD:   cmd_o    <= wdata_i[7:0];
          RA_ADDR:  addr_o   <= wdata_i[23:0];
          RA_DATA0: data0_o  <= wdata_i;
          RA_DATA1: data1_o  <= wdata_i;
          RA_GO:    if (wdata_i[0]) trig_o <= 1'b1;
          default: ;
        endcase
      end
      if (load_i) data0_o <= load_val_i;
      if (done_i) trig_o <= 1'b0;
      if (fail_set_i) fail_o <= 1'b1;
      else if (wr_i && waddr_i == RA_CTRL && wdata_i[FAIL_BIT]) fail_o <= 1'b0;
    end
  end

  always_comb begin
    case (waddr_i)
      RA_CTRL:  rdata_o = {28'd0, fail_o, upd_en_o};
      RA_CMD:   rdata_o = {24'd0, cmd_o};
      RA_ADDR:  rdata_o = {8'd0, addr_o};
      RA_DATA0: rdata_o = data0_o;
      RA_DATA1: rdata_o = data1_o;
      RA_GO:    rdata_o = {31'd0, trig_o};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/flash_isp_ctrl.sv
module flash_isp_ctrl
  import flash_isp_pkg::*;
#(
  parameter int          PAGE_BYTES = 2048,
  parameter int          APP_PAGES  = 2,
  parameter int          LDR_PAGES  = 2,
  parameter int          SPR_PAGES  = 1,
  parameter int          CFG_PAGES  = 1,
  parameter logic [31:0] DEVICE_ID  = 32'h0045_1A00,
  parameter logic [95:0] UID        = 96'h1357_9BDF_2468_ACE0_0F1E_2D3C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        busy
);
  localparam int PW      = PAGE_BYTES / 4;
  localparam int APP_W   = APP_PAGES * PW;
  localparam int LDR_W   = LDR_PAGES * PW;
  localparam int SPR_W   = SPR_PAGES * PW;
  localparam int CFG_W   = CFG_PAGES * PW;
  localparam int TOTAL_W = APP_W + LDR_W + SPR_W + CFG_W;
  localparam int IW      = $clog2(TOTAL_W);
  localparam int CW      = $clog2(TOTAL_W + 1);

  logic [7:0]    cmd_q;
  logic [23:0]   addr_q;
  logic [31:0]   data0_q, data1_q, konst, load_val, sum_val, mem_rdata, mem_wdata;
  logic [2:0]    upd_en_q;
  logic          fail_q, trig_q, done, fail_set, load, mem_we;
  isp_plan_t     plan;
  logic [IW-1:0] start_idx, mem_addr;
  logic [CW-1:0] count;

  flash_isp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .waddr_i(reg_addr), .wdata_i(reg_wdata),
    .done_i(done), .fail_set_i(fail_set), .load_i(load), .load_val_i(load_val),
    .cmd_o(cmd_q), .addr_o(addr_q), .data0_o(data0_q), .data1_o(data1_q),
    .upd_en_o(upd_en_q), .fail_o(fail_q), .trig_o(trig_q), .rdata_o(reg_rdata)
  );

  flash_isp_decode #(
    .PAGE_BYTES(PAGE_BYTES), .APP_W(APP_W), .LDR_W(LDR_W), .SPR_W(SPR_W), .CFG_W(CFG_W),
    .IW(IW), .CW(CW), .DEVICE_ID(DEVICE_ID), .UID(UID)
  ) u_dec (
    .cmd_i(cmd_q), .addr_i(addr_q), .size_i(data0_q), .upd_en_i(upd_en_q), .sum_i(sum_val),
    .plan_o(plan), .start_o(start_idx), .count_o(count), .konst_o(konst)
  );

  flash_isp_engine #(.IW(IW), .CW(CW)) u_eng (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_q), .plan_i(plan), .start_i(start_idx),
    .count_i(count), .konst_i(konst), .d0_i(data0_q), .d1_i(data1_q),
    .mem_rdata_i(mem_rdata), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .done_o(done), .fail_set_o(fail_set), .load_o(load),
    .load_val_o(load_val), .sum_o(sum_val)
  );

  flash_isp_array #(.WORDS(TOTAL_W), .IW(IW)) u_arr (
    .clk(clk), .we_i(mem_we), .addr_i(mem_addr), .wdata_i(mem_wdata), .rdata_o(mem_rdata)
  );

  assign busy = trig_q;
endmodule

// File: rtl/flash_isp_chk.sv
module flash_isp_chk #(
  parameter int IW    = 12,
  parameter int APP_W = 1024,
  parameter int LDR_W = 1024,
  parameter int SPR_W = 512
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic          wd_go,
  input logic          wd_clr,
  input logic          trig,
  input logic          fail,
  input logic [7:0]    cmd,
  input logic [23:0]   addr,
  input logic [2:0]    upd_en,
  input logic          mem_we,
  input logic [IW-1:0] mem_addr
);
  assert_go_from_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig) |-> $past(reg_wr && reg_addr == 3'd5 && wd_go));

  assert_write_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> trig);

  assert_regs_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && $past(trig)) |-> ($stable(cmd) && $stable(addr) && $stable(upd_en)));

  assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !(reg_wr && reg_addr == 3'd0 && wd_clr)) |=> fail);

  assert_gate_app_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr < IW'(APP_W)) |-> upd_en[0]);

  assert_gate_ldr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr >= IW'(APP_W) && mem_addr < IW'(APP_W + LDR_W)) |-> upd_en[1]);

  assert_gate_cfg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr >= IW'(APP_W + LDR_W + SPR_W)) |-> upd_en[2]);
endmodule

bind flash_isp_ctrl flash_isp_chk #(
  .IW(IW), .APP_W(APP_W), .LDR_W(LDR_W), .SPR_W(SPR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .wd_go(reg_wdata[0]), .wd_clr(reg_wdata[3]), .trig(trig_q), .fail(fail_q),
  .cmd(cmd_q), .addr(addr_q), .upd_en(upd_en_q), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/flash_isp_ctrl_tb.sv
module flash_isp_ctrl_tb;
  localparam int          TOTAL  = 3072;
  localparam logic [31:0] TB_DID = 32'hC0DE_0451;
  localparam logic [95:0] TB_UID = 96'hAAAA_0003_BBBB_0002_CCCC_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        busy;

  int          nchk = 0;
  int          nfail = 0;
  logic [31:0] model [TOTAL];
  logic [2:0]  en = 3'd0;

  always #5 clk = ~clk;

  flash_isp_ctrl #(.DEVICE_ID(TB_DID), .UID(TB_UID)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy)
  );

  function automatic int widx(logic [23:0] a);
    int b;
    case (a[21:20])
      2'd0:    b = 0;
      2'd1:    b = 1024;
      2'd2:    b = 2048;
      default: b = 2560;
    endcase
    return b + int'(a[19:2]);
  endfunction

  function automatic logic [31:0] msum(logic [23:0] a, int words);
    logic [31:0] s = '0;
    for (int i = 0; i < words; i++) s += model[widx(a) + i];
    return s;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      rd(3'd5, v);
      if (!v[0]) return;
    end
    chk("R2 start bit never cleared", v, 32'd0);
  endtask

  task automatic op(logic [7:0] c, logic [23:0] a, logic [31:0] d0, logic [31:0] d1,
                    output logic f, output logic [31:0] r);
    logic [31:0] v;
    wr(3'd0, {28'd0, 1'b1, en});
    wr(3'd1, {24'd0, c});
    wr(3'd2, {8'd0, a});
    wr(3'd3, d0);
    wr(3'd4, d1);
    wr(3'd5, 32'd1);
    wait_done();
    rd(3'd0, v); f = v[3];
    rd(3'd3, r);
  endtask

  task automatic rd_word(string tag, logic [23:0] a);
    logic f; logic [31:0] r;
    op(8'h00, a, 32'd0, 32'd0, f, r);
    chk({tag, " fail"}, {31'd0, f}, 32'd0);
    chk(tag, r, model[widx(a)]);
  endtask

  task automatic expect_fail(string tag, logic [7:0] c, logic [23:0] a, logic [31:0] d0);
    logic f; logic [31:0] r;
    op(c, a, d0, 32'h0, f, r);
    chk(tag, {31'd0, f}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R2 watchdog expired actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic f;
    logic [31:0] r, v, d;
    logic [23:0] a;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 6; i++) begin
      rd(3'(i), v);
      chk($sformatf("R1 reg %0d after reset", i), v, 32'd0);
    end

    // R8 / R9: erase with updates disabled fails; flag sticky and W1C
    wr(3'd1, 32'h22); wr(3'd2, 32'h0); wr(3'd5, 32'd1);
    wait_done();
    rd(3'd0, v); chk("R8 erase locked app sets fail", v, 32'h8);
    wr(3'd0, 32'h0);
    rd(3'd0, v); chk("R9 writing 0 keeps fail", v, 32'h8);
    wr(3'd0, 32'h8);
    rd(3'd0, v); chk("R9 W1C clears fail", v, 32'h0);
    expect_fail("R9 undefined command", 8'h55, 24'h0, 32'h0);

    // R7 erase every page with updates enabled
    en = 3'b111;
    for (int p = 0; p < 6; p++) begin
      a = (p < 2) ? 24'(p * 2048) : (p < 4) ? 24'(24'h100000 + (p - 2) * 2048)
        : (p == 4) ? 24'h200000 : 24'h300000;
      op(8'h22, a, 32'h0, 32'h0, f, r);
      chk("R7 erase page no fail", {31'd0, f}, 32'd0);
      for (int w = 0; w < 512; w++) model[widx(a) + w] = 32'hFFFF_FFFF;
    end
    rd_word("R7 erased word app", 24'h0007FC);
    rd_word("R7 erased word cfg", 24'h300010);

    // R5 / R4 program is AND
    op(8'h21, 24'h000040, 32'hF0F0_1234, 32'h0, f, r);
    model[widx(24'h40)] &= 32'hF0F0_1234;
    op(8'h21, 24'h000040, 32'h0FFF_FF00, 32'h0, f, r);
    model[widx(24'h40)] &= 32'h0FFF_FF00;
    rd_word("R5 double program ANDs", 24'h000040);
    chk("R5 value", model[widx(24'h40)], 32'h00F0_1200);

    // R6 64-bit program
    op(8'h61, 24'h100018, 32'h1111_2222, 32'h3333_4444, f, r);
    chk("R6 program64 no fail", {31'd0, f}, 32'd0);
    model[widx(24'h100018)] &= 32'h1111_2222;
    model[widx(24'h10001C)] &= 32'h3333_4444;
    rd_word("R6 low word", 24'h100018);
    rd_word("R6 high word", 24'h10001C);
    expect_fail("R6 misaligned 64-bit", 8'h61, 24'h100004, 32'h0);
    rd_word("R6 misaligned left word", 24'h100004);

    // R7 erase restores page and alignment
    expect_fail("R7 unaligned erase", 8'h22, 24'h000004, 32'h0);
    rd_word("R7 unaligned erase no change", 24'h000040);
    op(8'h22, 24'h000000, 32'h0, 32'h0, f, r);
    for (int w = 0; w < 512; w++) model[w] = 32'hFFFF_FFFF;
    rd_word("R7 erase restores ones", 24'h000040);

    // R12 address range
    expect_fail("R12 past app end", 8'h00, 24'h001000, 32'h0);
    expect_fail("R12 past loader end", 8'h00, 24'h101000, 32'h0);
    expect_fail("R12 past special end", 8'h00, 24'h200800, 32'h0);
    expect_fail("R12 high bits set", 8'h00, 24'h400000, 32'h0);
    expect_fail("R12 unaligned word", 8'h00, 24'h000002, 32'h0);
    rd_word("R12 last app word", 24'h000FFC);
    rd_word("R12 last config word", 24'h3007FC);

    // R10 identifiers
    op(8'h0B, 24'h0, 32'h0, 32'h0, f, r); chk("R10 company id", r, 32'hDA);
    op(8'h0C, 24'h4, 32'h0, 32'h0, f, r); chk("R10 device id", r, TB_DID);
    for (int k = 0; k < 3; k++) begin
      op(8'h04, 24'(k * 4), 32'h0, 32'h0, f, r);
      chk($sformatf("R10 uid word %0d", k), r, TB_UID[k*32 +: 32]);
    end
    expect_fail("R10 uid index 3", 8'h04, 24'hC, 32'h0);

    // R8 locked loader leaves array; special writable without enables
    en = 3'b001;
    expect_fail("R8 program locked loader", 8'h21, 24'h100020, 32'h0);
    rd_word("R8 locked loader unchanged", 24'h100020);
    expect_fail("R8 program locked config", 8'h21, 24'h300000, 32'h0);
    en = 3'b000;
    op(8'h21, 24'h200008, 32'h5A5A_5A5A, 32'h0, f, r);
    chk("R8 special always writable", {31'd0, f}, 32'd0);
    model[widx(24'h200008)] &= 32'h5A5A_5A5A;
    rd_word("R8 special value", 24'h200008);
    en = 3'b111;

    // R11 checksum
    op(8'h2D, 24'h200000, 32'd64, 32'h0, f, r);
    chk("R11 sum run ok", {31'd0, f}, 32'd0);
    op(8'h0D, 24'h0, 32'h0, 32'h0, f, r);
    chk("R11 sum result", r, msum(24'h200000, 16));
    expect_fail("R11 size not multiple of 4", 8'h2D, 24'h0, 32'd6);
    expect_fail("R11 range past region", 8'h2D, 24'h200700, 32'd1024);
    op(8'h0D, 24'h0, 32'h0, 32'h0, f, r);
    chk("R11 failed run keeps last sum", r, msum(24'h200000, 16));
    op(8'h2D, 24'h000010, 32'd0, 32'h0, f, r);
    op(8'h0D, 24'h0, 32'h0, 32'h0, f, r);
    chk("R11 zero size sum", r, 32'd0);

    // R3 frozen registers during a long erase
    wr(3'd1, 32'h22); wr(3'd2, 32'h200000); wr(3'd5, 32'd1);
    wr(3'd1, 32'h99); wr(3'd2, 32'h123); wr(3'd4, 32'h77); wr(3'd0, 32'h0);
    rd(3'd5, v); chk("R2 start bit high while running", v, 32'd1);
    wait_done();
    for (int w = 0; w < 512; w++) model[2048 + w] = 32'hFFFF_FFFF;
    rd(3'd1, v); chk("R3 command held", v, 32'h22);
    rd(3'd2, v); chk("R3 address held", v, 32'h200000);
    rd(3'd4, v); chk("R3 data1 held", v, 32'h0);
    rd(3'd0, v); chk("R3 enables held", v, 32'h7);
    rd(3'd5, v); chk("R2 start bit cleared", v, 32'd0);

    // random mix against the model
    for (int n = 0; n < 60; n++) begin
      int kind, reg_sel, wmax;
      kind    = int'($urandom % 4);
      reg_sel = int'($urandom % 3);
      wmax    = (reg_sel == 2) ? 512 : 1024;
      a = 24'(((reg_sel == 0) ? 0 : (reg_sel == 1) ? 24'h100000 : 24'h300000)
              + (($urandom % wmax) * 4));
      d = $urandom | $urandom;
      case (kind)
        0: rd_word("R4 random read", a);
        1: begin
          op(8'h21, a, d, 32'h0, f, r);
          model[widx(a)] &= d;
          rd_word("R5 random program", a);
        end
        2: begin
          a[2] = 1'b0;
          op(8'h61, a, d, ~d, f, r);
          model[widx(a)] &= d;
          model[widx(a) + 1] &= ~d;
          rd_word("R6 random program64 low", a);
        end
        default: begin
          int words;
          words = int'($urandom % 32);
          a = 24'({a[23:20], 20'h0} + (($urandom % (wmax - 32)) * 4));
          op(8'h2D, a, 32'(words * 4), 32'h0, f, r);
          op(8'h0D, 24'h0, 32'h0, 32'h0, f, r);
          chk("R11 random checksum", r, msum(a, words));
        end
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule